// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects interrupt requests from a set of devices (four by default) into a pending register. A software-written mask register blocks sources one by one. A fixed-priority encoder then picks the winning source among those that are both pending and unmasked, and reports its index and a valid flag. Every source's priority follows its bit position. With the default option, the highest index wins.

The line to the processor is gated by a global enable flag and by an in-service flag. The processor raises a take strobe when it accepts the interrupt, and this sets the in-service flag. Software then opens the masks of the more urgent sources, clears the in-service flag and re-enables. The handler clears the pending bit of the source it served. A more urgent source can then break into a running handler, while the less urgent ones stay blocked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no bit is pending, no source is masked, the enable and in-service flags are 0, `act_valid` is 0, `cpu_irq` is 0 and `act_idx` is 0.
- R2: A 1 on `dev_req[i]` during one clock edge sets pending bit i. The bit stays set after the request is removed, until software clears it.
- R3: `act_idx` is the highest index among the bits that are pending and unmasked. When source 3 is pending and unmasked, `act_idx` is 3 whatever the other bits are.
- R4: `act_valid` is 1 exactly when at least one pending bit is unmasked.
- R5: Write opcode 0 sets the mask bits where `wr_data` is 1, and a masked source cannot drive `act_valid` or `act_idx`. Opcode 1 clears those mask bits again. The pending bit is kept while its source is masked.
- R6: Write opcode 2 clears the pending bits where `wr_data` is 1.
- R7: When a device request and a pending-clear hit the same bit in the same cycle, the bit ends up set.
- R8: `cpu_irq` is 1 exactly when the enable flag is 1, the in-service flag is 0 and `act_valid` is 1.
- R9: `irq_take` sets the in-service flag on the next edge only while `cpu_irq` is 1. At any other time it has no effect.
- R10: Opcode 3 sets the enable flag and opcode 4 clears it. Opcode 5 sets the in-service flag and opcode 6 clears it. These opcodes take effect only when `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NUM_SRC | Device request bits, sampled each edge |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Write opcode (see R5, R6, R10) |
| wr_data | input | NUM_SRC | Per-source bit select for the write |
| irq_take | input | 1 | Processor accepts the interrupt |
| act_idx | output | IDX_W | Index of the winning source |
| act_valid | output | 1 | Some unmasked source is pending |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
On every cycle, the assertions check the following:
- A request is held in the pending register on the next edge, even against a same-cycle clear.
- A clear with no competing request empties the selected bits.
- The reported index points at a pending, unmasked source, with nothing more urgent above it.
- The processor line never rises without enable, or while a handler is in service.
- A take while the line is high always marks a handler as in service.

Some behaviours appear only in the bench's scenarios:
- The index order for particular request mixes.
- The pending state surviving a mask.
- A more urgent source breaking in once the in-service flag is cleared.
- A take with the line low being ignored.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      OP_MASK_SET = 3'd0,
      OP_MASK_CLR = 3'd1,
      OP_PEND_CLR = 3'd2,
      OP_EN_SET   = 3'd3,
      OP_EN_CLR   = 3'd4,
      OP_SVC_SET  = 3'd5,
      OP_SVC_CLR  = 3'd6
   } wr_op_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_bits,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] pend
);
   // set has precedence over clear on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_bits) | set_bits;
   end

   // R2 / R7: any request bit is pending after the edge
   p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((pend & $past(set_bits)) == $past(set_bits)));

   // R6: uncontested clear empties the selected bits
   p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_bits != '0) && ((set_bits & clr_bits) == '0))
         |=> ((pend & $past(clr_bits)) == '0));
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_op,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               take_ok,
   output logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] pend_clr,
   output logic               en_flag,
   output logic               svc_flag
);
   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   logic is_mset, is_mclr, is_eset, is_eclr, is_sset, is_sclr;
   assign is_mset = wr_en && (op == OP_MASK_SET);
   assign is_mclr = wr_en && (op == OP_MASK_CLR);
   assign is_eset = wr_en && (op == OP_EN_SET);
   assign is_eclr = wr_en && (op == OP_EN_CLR);
   assign is_sset = wr_en && (op == OP_SVC_SET);
   assign is_sclr = wr_en && (op == OP_SVC_CLR);

   assign pend_clr = (wr_en && (op == OP_PEND_CLR)) ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '0;
         en_flag  <= 1'b0;
         svc_flag <= 1'b0;
      end else begin
         if (is_mset)      mask <= mask | wr_data;
         else if (is_mclr) mask <= mask & ~wr_data;
         if (is_eset)      en_flag <= 1'b1;
         else if (is_eclr) en_flag <= 1'b0;
         // accepting an interrupt outranks a software clear
         if (take_ok || is_sset) svc_flag <= 1'b1;
         else if (is_sclr)       svc_flag <= 1'b0;
      end
   end

   // R9: an accepted interrupt always marks a handler in service
   p_take_sets_svc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take_ok |=> svc_flag);

   // R10: enable only changes through its opcodes
   p_en_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_eset && !is_eclr) |=> $stable(en_flag));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC   = 4,
   parameter bit HIGH_WINS = 1'b1,
   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] act,
   output logic [IDX_W-1:0]   idx,
   output logic               valid
);
   assign valid = |act;

   if (HIGH_WINS) begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_SRC; i++)
            if (act[i]) idx = IDX_W'(i);
      end
   end else begin : g_low
      always_comb begin
         idx = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--)
            if (act[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_SRC   = 4,
   parameter bit HIGH_WINS = 1'b1,
   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] dev_req,
   input  logic               wr_en,
   input  logic [2:0]         wr_op,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               irq_take,
   output logic [IDX_W-1:0]   act_idx,
   output logic               act_valid,
   output logic               cpu_irq
);
   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_src
      $error("irq_prio_ctrl: NUM_SRC must be within 2..64");
   end

   logic [NUM_SRC-1:0] pend, mask, pend_clr, act;
   logic               en_flag, svc_flag;

   irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_bits(dev_req),
      .clr_bits(pend_clr), .pend(pend));

   irq_ctl_regs #(.NUM_SRC(NUM_SRC)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
      .wr_data(wr_data), .take_ok(irq_take & cpu_irq), .mask(mask),
      .pend_clr(pend_clr), .en_flag(en_flag), .svc_flag(svc_flag));

   assign act = pend & ~mask;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .HIGH_WINS(HIGH_WINS)) u_enc (
      .act(act), .idx(act_idx), .valid(act_valid));

   assign cpu_irq = en_flag & ~svc_flag & act_valid;

   // R3 / R5: the index names a pending, unmasked source
   p_idx_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (pend[act_idx] && !mask[act_idx]));

   // R3: nothing more urgent than the winner is active
   if (HIGH_WINS) begin : g_chk_high
      p_idx_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
         act_valid |-> ((act >> act_idx) == NUM_SRC'(1)));
   end

   // R8: processor line needs enable, no handler in service, and a source
   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (en_flag && !svc_flag && act_valid));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] dev_req = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_op = '0;
   logic [3:0] wr_data = '0;
   logic       irq_take = 1'b0;
   logic [1:0] act_idx;
   logic       act_valid;
   logic       cpu_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .wr_en(wr_en),
      .wr_op(wr_op), .wr_data(wr_data), .irq_take(irq_take),
      .act_idx(act_idx), .act_valid(act_valid), .cpu_irq(cpu_irq));

   task automatic chk(input string tag, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
      end
   endtask

   task automatic step(input logic [3:0] req, input logic we,
                       input logic [2:0] op, input logic [3:0] d,
                       input logic tk);
      @(negedge clk);
      dev_req = req; wr_en = we; wr_op = op; wr_data = d; irq_take = tk;
      @(negedge clk);
      dev_req = '0; wr_en = 1'b0; wr_op = '0; wr_data = '0; irq_take = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 valid", act_valid, 0);
      chk("R1 irq", cpu_irq, 0);
      chk("R1 idx", act_idx, 0);
   endtask

   task automatic t_pend_prio;
      step(4'b0010, 0, 0, 0, 0);
      chk("R2 held", act_valid, 1);
      chk("R3 idx1", act_idx, 1);
      step(4'b0101, 0, 0, 0, 0);
      chk("R3 idx2", act_idx, 2);
      step(4'b1000, 0, 0, 0, 0);
      chk("R3 src3 wins", act_idx, 3);
      step(0, 1, 3'd2, 4'b1000, 0);
      chk("R6 clr3", act_idx, 2);
      step(0, 1, 3'd2, 4'b1111, 0);
      chk("R6 R4 empty", act_valid, 0);
   endtask

   task automatic t_mask;
      step(4'b1010, 0, 0, 0, 0);
      step(0, 1, 3'd0, 4'b1000, 0);
      chk("R5 mask3 idx", act_idx, 1);
      step(0, 1, 3'd0, 4'b0010, 0);
      chk("R5 R4 all masked", act_valid, 0);
      step(0, 1, 3'd1, 4'b1010, 0);
      chk("R5 unmask keeps pend", act_idx, 3);
      chk("R4 valid back", act_valid, 1);
      step(0, 1, 3'd2, 4'b1111, 0);
   endtask

   task automatic t_set_wins;
      step(4'b0100, 1, 3'd2, 4'b0100, 0);
      chk("R7 set wins valid", act_valid, 1);
      chk("R7 set wins idx", act_idx, 2);
      step(0, 1, 3'd2, 4'b1111, 0);
      chk("R7 later clear", act_valid, 0);
   endtask

   task automatic t_irq;
      step(4'b0001, 0, 0, 0, 0);
      chk("R8 no enable", cpu_irq, 0);
      step(0, 0, 0, 0, 1);
      step(0, 1, 3'd3, 0, 0);
      chk("R10 R9 enable, stray take ignored", cpu_irq, 1);
      step(0, 0, 0, 0, 1);
      chk("R9 take sets svc", cpu_irq, 0);
      step(0, 1, 3'd0, 4'b0001, 0);
      step(4'b1000, 0, 0, 0, 0);
      chk("R8 svc blocks", cpu_irq, 0);
      step(0, 1, 3'd6, 0, 0);
      chk("R10 svc clr nests", cpu_irq, 1);
      chk("R3 nested idx", act_idx, 3);
      step(0, 1, 3'd5, 0, 0);
      chk("R10 svc set", cpu_irq, 0);
      step(0, 1, 3'd6, 0, 0);
      step(0, 1, 3'd4, 0, 0);
      chk("R10 enable clr", cpu_irq, 0);
      step(0, 0, 3'd3, 0, 0);
      chk("R10 no wr_en", cpu_irq, 0);
   endtask

   initial begin
      #1;
      t_reset;
      #9 rst_n = 1'b1;
      t_reset;
      t_pend_prio;
      t_mask;
      t_set_wins;
      t_irq;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule